// File: doc/BRIEF.md
# Hypervisor Call Trap Decoder

This block watches one instruction word per cycle and picks out the hypervisor-call instruction in either of two encodings. One is a fixed 32-bit word. The other is a compressed pair of halfwords. When it finds the instruction, it weighs the current privilege level, whether the hypervisor level is live in the current security state, and the enable and disable bits of the monitor and hypervisor levels. From these it reaches one verdict: the instruction is undefined, it is a no-op, or it is a hypervisor-call exception. On an exception it loads a syndrome register with the exception class and the 16-bit immediate, exactly as encoded. The handler reads that immediate, and the hardware gives it no meaning.

The verdict is kept in a four-state outcome register. The states are ST_QUIET (no instruction recognised), ST_UNDEF, ST_NOP and ST_CALL. Every clock edge takes the transition named by the input of that cycle. Any state moves to ST_QUIET when there is no valid hit. It moves to ST_UNDEF or ST_NOP when the verdict refuses the call. It moves to ST_CALL when the call is granted, and this is the only transition that writes the syndrome. Two parameters say how each unpredictable case resolves. ENC_AS_NOP covers the encoding cases. CONSTR_AS_NOP covers the case where the monitor has calls disabled while the core runs at hypervisor level. Both default to undefined.

Top module: `hcall_trap_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, undef_o, nop_o and take_o are 0, and syn_ec and syn_imm are 0.
- R2: With enc_compact=0, a word matches when bits[27:20]=0x14, bits[7:4]=0x7 and bits[31:28] is not 0xF. Its immediate is bits[19:8] above bits[3:0]. A word with bits[31:28]=0xF never matches.
- R3: With enc_compact=1, bits[31:16] hold the first halfword and bits[15:0] the second. A word matches when bits[31:20]=0xF7E and bits[15:12]=0x8. Its immediate is bits[19:16] above bits[11:0].
- R4: When in_valid is 0, or the word does not match, all three outcome outputs are 0 in the next cycle and the syndrome keeps its value.
- R5: cur_lvl encodes 0=user, 1=kernel, 2=hypervisor, 3=monitor. A match at level 0 or at level 3 gives undefined.
- R6: A match with hyp_live=0 gives undefined.
- R7: When mon_present=1, the call enable is mon_call_en and hyp_call_dis is ignored. When mon_present=0, the enable is NOT hyp_call_dis. An enable of 0 gives undefined.
- R8: When mon_present=1, mon_narrow=1, mon_call_en=0 and cur_lvl=2 all hold, the match resolves to undefined when CONSTR_AS_NOP=0 (the default) and to no-op when it is 1.
- R9: A fixed-encoding match with bits[31:28] not 0xE, or a compressed match with in_cond_blk=1, is unpredictable. It resolves to undefined when ENC_AS_NOP=0 (the default) and to no-op when it is 1. This check comes before the checks of R5 to R8. in_cond_blk is ignored for the fixed encoding.
- R10: A granted call raises take_o one cycle after the valid input. In that same cycle syn_ec=0x12 and syn_imm holds the immediate, and both stay until the next granted call.
- R11: At most one of undef_o, nop_o and take_o is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on in_word is live this cycle |
| in_word | input | 32 | Instruction word |
| enc_compact | input | 1 | 0 = fixed 32-bit encoding, 1 = compressed halfword pair |
| in_cond_blk | input | 1 | Compressed word sits inside a conditional block |
| cur_lvl | input | 2 | Current privilege level |
| hyp_live | input | 1 | Hypervisor level is implemented and enabled in the current security state |
| mon_present | input | 1 | Monitor level is implemented |
| mon_narrow | input | 1 | Monitor level runs in the 32-bit execution state |
| mon_call_en | input | 1 | Monitor's hypervisor-call enable bit |
| hyp_call_dis | input | 1 | Hypervisor configuration's call-disable bit |
| undef_o | output | 1 | Instruction is undefined |
| nop_o | output | 1 | Instruction resolves to a no-op |
| take_o | output | 1 | Hypervisor-call exception is taken |
| syn_ec | output | 6 | Syndrome exception class |
| syn_imm | output | 16 | Syndrome immediate |

## Verification
Each outcome and the syndrome appear exactly one clock edge after the cycle that presents the word. So the bench computes the expected values from the inputs it drives before that edge and compares them at the following falling edge. Every cycle is compared against two instances, one with each resolution setting, so that the refusal paths and the no-op paths are told apart. The syndrome expectation changes only on a predicted call. Every non-call cycle therefore also confirms that the register held its value.

// File: rtl/hcall_pkg.sv
package hcall_pkg;

    localparam int IMM_W = 16;
    localparam int EC_W  = 6;
    localparam int HALF_W = IMM_W;
    localparam int WORD_W = 2 * HALF_W;
    localparam logic [EC_W-1:0] EC_HCALL = 6'h12;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_KERN = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_UNDEF = 2'd1,
        ST_NOP   = 2'd2,
        ST_CALL  = 2'd3
    } out_st_e;

    typedef struct packed {
        logic             hit;
        logic             unpred;
        logic [IMM_W-1:0] imm;
    } dec_t;

endpackage

// File: rtl/hcall_match.sv
module hcall_match
    import hcall_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              compact,
    input  logic              cond_blk,
    output dec_t              dec
);

    logic             fx_hit, fx_unp, cp_hit;
    logic [IMM_W-1:0] fx_imm, cp_imm;

    always_comb begin
        // fixed encoding: cond field on top, opcode bytes split around imm12
        fx_hit = (word[31:28] != 4'hF) && (word[27:20] == 8'h14) && (word[7:4] == 4'h7);
        fx_unp = (word[31:28] != 4'hE);
        fx_imm = {word[19:8], word[3:0]};
        // compressed pair: first halfword in the upper half
        cp_hit = (word[31:20] == 12'hF7E) && (word[15:12] == 4'h8);
        cp_imm = {word[19:16], word[11:0]};
    end

    always_comb begin
        if (compact) begin
            dec.hit    = cp_hit;
            dec.unpred = cond_blk;
            dec.imm    = cp_imm;
        end else begin
            dec.hit    = fx_hit;
            dec.unpred = fx_unp;
            dec.imm    = fx_imm;
        end
    end

endmodule

// File: rtl/hcall_gate.sv
module hcall_gate
    import hcall_pkg::*;
#(
    parameter bit CONSTR_AS_NOP = 1'b0
) (
    input  lvl_e    lvl,
    input  logic    hyp_live,
    input  logic    mon_present,
    input  logic    mon_narrow,
    input  logic    mon_call_en,
    input  logic    hyp_call_dis,
    output out_st_e verdict
);

    localparam out_st_e CONSTR_RES = CONSTR_AS_NOP ? ST_NOP : ST_UNDEF;

    logic bad_level;
    logic call_en;
    logic constr;

    always_comb begin
        bad_level = (lvl == LVL_USER) || (lvl == LVL_MON) || !hyp_live;
        call_en   = mon_present ? mon_call_en : !hyp_call_dis;
        constr    = mon_present && mon_narrow && !mon_call_en && (lvl == LVL_HYP);
    end

    always_comb begin
        if (bad_level)
            verdict = ST_UNDEF;
        else if (constr)
            verdict = CONSTR_RES;
        else if (!call_en)
            verdict = ST_UNDEF;
        else
            verdict = ST_CALL;
    end

endmodule

// File: rtl/hcall_trap_unit.sv
module hcall_trap_unit
    import hcall_pkg::*;
#(
    parameter bit ENC_AS_NOP    = 1'b0,
    parameter bit CONSTR_AS_NOP = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_word,
    input  logic        enc_compact,
    input  logic        in_cond_blk,
    input  logic [1:0]  cur_lvl,
    input  logic        hyp_live,
    input  logic        mon_present,
    input  logic        mon_narrow,
    input  logic        mon_call_en,
    input  logic        hyp_call_dis,
    output logic        undef_o,
    output logic        nop_o,
    output logic        take_o,
    output logic [5:0]  syn_ec,
    output logic [15:0] syn_imm
);

    localparam out_st_e ENC_RES = ENC_AS_NOP ? ST_NOP : ST_UNDEF;

    dec_t    dec;
    out_st_e verdict;
    out_st_e state_q, state_d;
    logic [EC_W-1:0]  ec_q;
    logic [IMM_W-1:0] imm_q;

    hcall_match u_match (
        .word     (in_word),
        .compact  (enc_compact),
        .cond_blk (in_cond_blk),
        .dec      (dec)
    );

    hcall_gate #(
        .CONSTR_AS_NOP (CONSTR_AS_NOP)
    ) u_gate (
        .lvl          (lvl_e'(cur_lvl)),
        .hyp_live     (hyp_live),
        .mon_present  (mon_present),
        .mon_narrow   (mon_narrow),
        .mon_call_en  (mon_call_en),
        .hyp_call_dis (hyp_call_dis),
        .verdict      (verdict)
    );

    // next outcome: encoding check precedes privilege gate
    always_comb begin
        if (!in_valid || !dec.hit)
            state_d = ST_QUIET;
        else if (dec.unpred)
            state_d = ENC_RES;
        else
            state_d = verdict;
    end

    // state register and syndrome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            ec_q    <= '0;
            imm_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_CALL) begin
                ec_q  <= EC_HCALL;
                imm_q <= dec.imm;
            end
        end
    end

    // outputs from state
    always_comb begin
        undef_o = 1'b0;
        nop_o   = 1'b0;
        take_o  = 1'b0;
        unique case (state_q)
            ST_QUIET: ;
            ST_UNDEF: undef_o = 1'b1;
            ST_NOP:   nop_o   = 1'b1;
            ST_CALL:  take_o  = 1'b1;
        endcase
    end

    assign syn_ec  = ec_q;
    assign syn_imm = imm_q;

endmodule

// File: rtl/hcall_trap_chk.sv
module hcall_trap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  cur_lvl,
    input logic        mon_present,
    input logic        hyp_call_dis,
    input logic        undef_o,
    input logic        nop_o,
    input logic        take_o,
    input logic [5:0]  syn_ec,
    input logic [15:0] syn_imm
);

    AST_QUIET_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(undef_o || nop_o || take_o)); // R4

    AST_SYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> ($stable(syn_imm) && $stable(syn_ec))); // R4

    AST_USER_NO_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_lvl == 2'd0) |=> !take_o); // R5

    AST_DISABLED_NO_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mon_present && hyp_call_dis) |=> !take_o); // R7

    AST_EC_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (syn_ec == 6'h12)); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_o, nop_o, take_o})); // R11

endmodule

bind hcall_trap_unit hcall_trap_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .cur_lvl      (cur_lvl),
    .mon_present  (mon_present),
    .hyp_call_dis (hyp_call_dis),
    .undef_o      (undef_o),
    .nop_o        (nop_o),
    .take_o       (take_o),
    .syn_ec       (syn_ec),
    .syn_imm      (syn_imm)
);

// File: tb/sim_hcall_trap_unit.sv
`timescale 1ns/1ps
module sim_hcall_trap_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        v = 1'b0, cmp = 1'b0, cblk = 1'b0;
    logic [31:0] w = '0;
    logic [1:0]  lv = 2'd1;
    logic        live = 1'b1, mp = 1'b0, mn = 1'b0, men = 1'b1, hd = 1'b0;

    logic        un0, np0, tk0, un1, np1, tk1;
    logic [5:0]  ec0, ec1;
    logic [15:0] im0, im1;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [24:0] exp0 = '0, exp1 = '0;
    logic [15:0] held0 = '0, held1 = '0;

    hcall_trap_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_word(w), .enc_compact(cmp),
        .in_cond_blk(cblk), .cur_lvl(lv), .hyp_live(live), .mon_present(mp),
        .mon_narrow(mn), .mon_call_en(men), .hyp_call_dis(hd),
        .undef_o(un0), .nop_o(np0), .take_o(tk0), .syn_ec(ec0), .syn_imm(im0)
    );

    hcall_trap_unit #(.ENC_AS_NOP(1'b1), .CONSTR_AS_NOP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_word(w), .enc_compact(cmp),
        .in_cond_blk(cblk), .cur_lvl(lv), .hyp_live(live), .mon_present(mp),
        .mon_narrow(mn), .mon_call_en(men), .hyp_call_dis(hd),
        .undef_o(un1), .nop_o(np1), .take_o(tk1), .syn_ec(ec1), .syn_imm(im1)
    );

    function automatic logic [31:0] fx(input logic [3:0] cond, input logic [15:0] imm);
        return {cond, 8'h14, imm[15:4], 4'h7, imm[3:0]};
    endfunction

    function automatic logic [31:0] cp(input logic [15:0] imm);
        return {12'hF7E, imm[15:12], 4'h8, imm[11:0]};
    endfunction

    // behavioural model: 0 quiet, 1 undef, 2 nop, 3 call
    function automatic int model(input bit enc_nop, input bit con_nop, output logic [15:0] imm);
        bit matched, unp;
        int lvl_i;
        bit en;
        lvl_i = int'(lv);
        if (cmp) begin
            matched = (w[31:16] >> 4) == 16'h0F7E && (w[15:0] >> 12) == 16'h8;
            unp = cblk;
            imm = {w[19:16], w[11:0]};
        end else begin
            matched = (w[27:20] == 8'h14) && (w[7:4] == 4'h7) && (w[31:28] != 4'hF);
            unp = (w[31:28] != 4'hE);
            imm = {w[19:8], w[3:0]};
        end
        if (!v || !matched) return 0;
        if (unp) return enc_nop ? 2 : 1;
        if (lvl_i == 0 || lvl_i == 3 || !live) return 1;
        if (mp && mn && !men && lvl_i == 2) return con_nop ? 2 : 1;
        en = mp ? men : !hd;
        if (!en) return 1;
        return 3;
    endfunction

    function automatic logic [24:0] pack(input int o, input logic [15:0] held);
        logic [5:0] ec;
        ec = (held == 16'h0 && o != 3) ? 6'h0 : 6'h12;
        return {o == 1, o == 2, o == 3, ec, held};
    endfunction

    bit any_call0 = 0, any_call1 = 0;

    task automatic cmp_one(input string tag, input string who, input logic [24:0] act, input logic [24:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual={u%0b n%0b t%0b ec=%h imm=%h} expected={u%0b n%0b t%0b ec=%h imm=%h}",
                     tag, who, act[24], act[23], act[22], act[21:16], act[15:0],
                     exp[24], exp[23], exp[22], exp[21:16], exp[15:0]);
        end
    endtask

    // compute expectations from current inputs, clock once, compare at falling edge
    task automatic tick(input string tag);
        logic [15:0] i0, i1;
        int o0, o1;
        o0 = model(1'b0, 1'b0, i0);
        o1 = model(1'b1, 1'b1, i1);
        if (o0 == 3) begin held0 = i0; any_call0 = 1; end
        if (o1 == 3) begin held1 = i1; any_call1 = 1; end
        exp0 = {o0 == 1, o0 == 2, o0 == 3, any_call0 ? 6'h12 : 6'h0, held0};
        exp1 = {o1 == 1, o1 == 2, o1 == 3, any_call1 ? 6'h12 : 6'h0, held1};
        @(posedge clk);
        @(negedge clk);
        cmp_one(tag, "u0", {un0, np0, tk0, ec0, im0}, exp0);
        cmp_one(tag, "u1", {un1, np1, tk1, ec1, im1}, exp1);
    endtask

    task automatic ok_cfg();
        v = 1; lv = 2'd1; live = 1; mp = 0; mn = 0; men = 1; hd = 0; cblk = 0; cmp = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        total++;
        if ({un0, np0, tk0, ec0, im0, un1, np1, tk1, ec1, im1} !== '0) begin
            bad++;
            $display("FAIL R1 reset: actual=%h expected=0", {un0, np0, tk0, ec0, im0});
        end
        rst_n = 1;
        tick("R1");

        // R2: fixed encoding
        ok_cfg(); w = fx(4'hE, 16'hA5C3); tick("R2");
        w = fx(4'hE, 16'h0000); tick("R2");
        w = fx(4'hE, 16'hFFFF); tick("R2");
        w = fx(4'hF, 16'h1234); tick("R2");

        // R3: compressed encoding
        cmp = 1; w = cp(16'h3E71); tick("R3");
        w = cp(16'hC00D); tick("R3");

        // R4: ignored inputs keep syndrome
        v = 0; w = cp(16'h5555); tick("R4");
        v = 1; cmp = 0; w = 32'h12345678; tick("R4");
        cmp = 1; w = cp(16'h7777) ^ 32'h0000_1000; tick("R4");
        cmp = 0; w = fx(4'hE, 16'h0F0F) ^ 32'h0000_0010; tick("R4");

        // R5: privilege levels
        ok_cfg(); w = fx(4'hE, 16'h1111);
        lv = 2'd0; tick("R5");
        lv = 2'd3; tick("R5");
        lv = 2'd2; tick("R5");

        // R6: hypervisor level not live
        ok_cfg(); live = 0; w = cp(16'h2222); cmp = 1; tick("R6");

        // R7: enable selection
        ok_cfg(); w = fx(4'hE, 16'h3333);
        hd = 1; tick("R7");
        mp = 1; men = 0; hd = 0; tick("R7");
        mp = 1; men = 1; hd = 1; tick("R7");

        // R8: constrained case
        ok_cfg(); mp = 1; mn = 1; men = 0; lv = 2'd2; w = fx(4'hE, 16'h4444); tick("R8");
        lv = 2'd1; tick("R8");

        // R9: unpredictable encodings
        ok_cfg(); w = fx(4'h0, 16'h5151); tick("R9");
        lv = 2'd0; tick("R9");
        ok_cfg(); cmp = 1; cblk = 1; w = cp(16'h6161); tick("R9");
        cmp = 0; w = fx(4'hE, 16'h7171); tick("R9");

        // R10: back-to-back calls and hold
        ok_cfg(); w = fx(4'hE, 16'h8001); tick("R10");
        cmp = 1; w = cp(16'h9002); tick("R10");
        v = 0; tick("R10");
        v = 1; cmp = 0; w = fx(4'hE, 16'hB003); tick("R10");

        // R11: configuration sweep
        for (int k = 0; k < 128; k++) begin
            v = 1; cblk = 0; cmp = k[6];
            w = cmp ? cp(16'(k * 331)) : fx(4'hE, 16'(k * 331));
            lv = k[1:0]; live = k[2]; mp = k[3]; mn = k[4]; men = k[5]; hd = ~k[5] ^ k[0];
            tick("R11");
        end

        v = 0; tick("R4");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule